// File: doc/BRIEF.md
# Fractional Clock Divider with Triangle Spread

This block turns a stream of source-clock events into a slower output clock whose period is a programmable fractional number of source events. Each output period lasts either N or N+1 selected events. The choice comes from a 24-bit phase accumulator: the accumulator adds the fractional word at every period boundary, and its carry lengthens the next period by one event. A second event input lets the divider count the output of a neighbouring divider instead of the primary source, so two dividers can be chained to reach very low rates (for example 12.288 MHz divided by 256 gives 48 kHz).

An optional spread engine adds a signed offset to the fractional word at every period boundary. The offset follows a triangle: it climbs by a programmed step for a programmed number of periods, then falls back over the same number of periods. In down-spread mode the offset only lengthens periods. In centre-spread mode it is shifted by half its peak, so the ratio swings evenly about the nominal value. A synchronisation pulse restarts the divider so that several copies start in step, all with their falling edges at period boundaries. Bypass (explicit, or an integer word below 2) forwards the selected event stream unchanged.

Top module: `fdiv_spread`

## Requirements
- R1: With `int_only` high, every output period lasts exactly `int_word` selected events. The fractional word and the spread offset have no effect.
- R2: With `int_only` low and spread off, the first period after a restart lasts `int_word` events and loads the accumulator with `frac_word`. At every later boundary the sum s = acc + `frac_word` is formed, the next period lasts `int_word` + floor(s / 2^24), and acc becomes s mod 2^24.
- R3: `div_out` falls at each boundary in the same cycle that `div_tick` pulses. It rises once floor(L/2) events of a period of length L have been counted. Both outputs are registered and change on the clock edge that samples the deciding event.
- R4: A new `int_word` or `frac_word` first shapes the period that starts at the next boundary. The period in progress keeps its length.
- R5: When `bypass` is high or `int_word` is below 2, both `div_out` and `div_tick` equal the selected event input of the previous cycle. The first event after leaving bypass pulses `div_tick`, drives `div_out` low, and starts the sequence as a restart does.
- R6: With `casc_sel` high, periods are counted in `casc_tick` events and `src_tick` is ignored. With `casc_sel` low, the roles are reversed.
- R7: A `sync` pulse drives `div_out` and `div_tick` low on the next edge, clears the accumulator and the triangle, and starts a period of `int_word` events. An event in the same cycle as `sync` is not counted.
- R8: In down spread (`ss_en`=1, `ss_center`=0), the offset used at the k-th boundary after a restart follows the triangle 0, S, 2S, ..., H*S, (H-1)*S, ..., 0, where S is `ss_step` and H is `ss_leg`. The offset is added to `frac_word` in the sum of R2. The first period after a restart is unspread.
- R9: In centre spread (`ss_center`=1), the offset is the R8 triangle value minus floor(H*S/2). It can be negative, and a negative sum shortens a period to `int_word`-1.
- R10: After reset both outputs are low and the block passes events straight through until the first event or `sync`.
- R11: With `ss_en` low or `ss_leg` zero, the periods are the same as with spread off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock; all events are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 1 | Primary source event, one cycle per source clock edge |
| casc_tick | input | 1 | Event stream from a neighbouring divider |
| casc_sel | input | 1 | 1 selects `casc_tick`, 0 selects `src_tick` |
| sync | input | 1 | Restart pulse for aligned start-up |
| int_word | input | 12 | Integer part of the ratio |
| frac_word | input | 24 | Fractional part of the ratio, in units of 2^-24 |
| int_only | input | 1 | Ignore the fraction and the spread |
| bypass | input | 1 | Forward the selected events unchanged |
| ss_en | input | 1 | Enable triangle spread |
| ss_center | input | 1 | 1 centre spread, 0 down spread |
| ss_step | input | 16 | Offset change per output period |
| ss_leg | input | 8 | Periods per rising or falling leg of the triangle |
| div_out | output | 1 | Divided clock |
| div_tick | output | 1 | One-cycle strobe at each period boundary |

## Verification
Every result of this block is due one clock edge after the event or `sync` that causes it. The bench therefore drives inputs just after a falling edge and reads the outputs at the next falling edge, which sees exactly the edge that consumed the last driven event. A period length is compared when `div_tick` is seen, against a count of the selected events driven since the previous boundary. The rise of `div_out` is compared against half of the expected length at the sample where it first reads high. The expected lengths come from an arithmetic model of the accumulator and the triangle. That model is stepped at each observed boundary using the port values that were on the inputs at that edge, so a ratio change made in the middle of a period is expected to act only one boundary later.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  typedef enum logic {
    DIR_UP = 1'b0,
    DIR_DN = 1'b1
  } tri_dir_e;
endpackage

// File: rtl/fdiv_tri.sv
// Triangle offset generator: steps once per output-period boundary.
module fdiv_tri
  import fdiv_pkg::*;
#(
  parameter int FRAC_W = 24,
  parameter int STEP_W = 16,
  parameter int LEG_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     restart,
  input  logic                     adv,
  input  logic                     en,
  input  logic                     center,
  input  logic [STEP_W-1:0]        step,
  input  logic [LEG_W-1:0]         leg,
  output logic signed [FRAC_W:0]   ofs
);
  logic [FRAC_W-1:0] tri_q, tri_d, step_x, peak;
  logic [LEG_W-1:0]  k_q, k_d, k_inc;
  tri_dir_e          dir_q, dir_d;

  assign step_x = {{(FRAC_W-STEP_W){1'b0}}, step};
  assign peak   = step_x * {{(FRAC_W-LEG_W){1'b0}}, leg};
  assign k_inc  = k_q + 1'b1;

  always_comb begin
    tri_d = tri_q;
    k_d   = k_q;
    dir_d = dir_q;
    if (restart) begin
      tri_d = '0;
      k_d   = '0;
      dir_d = DIR_UP;
    end else if (adv && (leg != '0)) begin
      tri_d = (dir_q == DIR_UP) ? tri_q + step_x : tri_q - step_x;
      if (k_inc == leg) begin
        k_d   = '0;
        dir_d = (dir_q == DIR_UP) ? DIR_DN : DIR_UP;
      end else begin
        k_d = k_inc;
      end
    end
  end

  always_comb begin
    if (!en)
      ofs = '0;
    else if (center)
      ofs = $signed({1'b0, tri_q}) - $signed({2'b0, peak[FRAC_W-1:1]});
    else
      ofs = $signed({1'b0, tri_q});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tri_q <= '0;
      k_q   <= '0;
      dir_q <= DIR_UP;
    end else begin
      tri_q <= tri_d;
      k_q   <= k_d;
      dir_q <= dir_d;
    end
  end
endmodule

// File: rtl/fdiv_plan.sv
// Combinational period planner: next period length and accumulator value.
module fdiv_plan #(
  parameter int INT_W  = 12,
  parameter int FRAC_W = 24,
  localparam int LEN_W = INT_W + 2,
  localparam int SUM_W = FRAC_W + 3
) (
  input  logic [INT_W-1:0]       n,
  input  logic [FRAC_W-1:0]      f,
  input  logic                   io,
  input  logic                   byp_in,
  input  logic [FRAC_W-1:0]      acc_in,
  input  logic signed [FRAC_W:0] ofs,
  output logic [LEN_W-1:0]       len,
  output logic [FRAC_W-1:0]      acc_out,
  output logic                   byp_out
);
  logic signed [SUM_W-1:0] frac_part, sum;
  logic [2:0]              carry;

  always_comb begin
    frac_part = io ? '0
              : $signed({3'b0, f}) + $signed({{2{ofs[FRAC_W]}}, ofs});
    sum       = $signed({3'b0, acc_in}) + frac_part;
    carry     = sum[SUM_W-1:FRAC_W];
    len       = {2'b0, n} + {{(LEN_W-3){carry[2]}}, carry};
    acc_out   = sum[FRAC_W-1:0];
    byp_out   = byp_in | (n < INT_W'(2));
  end
endmodule

// File: rtl/fdiv_spread.sv
module fdiv_spread #(
  parameter int INT_W  = 12,
  parameter int FRAC_W = 24,
  parameter int STEP_W = 16,
  parameter int LEG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_tick,
  input  logic              casc_tick,
  input  logic              casc_sel,
  input  logic              sync,
  input  logic [INT_W-1:0]  int_word,
  input  logic [FRAC_W-1:0] frac_word,
  input  logic              int_only,
  input  logic              bypass,
  input  logic              ss_en,
  input  logic              ss_center,
  input  logic [STEP_W-1:0] ss_step,
  input  logic [LEG_W-1:0]  ss_leg,
  output logic              div_out,
  output logic              div_tick
);
  localparam int LEN_W = INT_W + 2;

  logic              sel_tick, bnd, fresh;
  logic [LEN_W-1:0]  cnt_q, cnt_d, cnt_inc, len_q, len_d, p_len;
  logic [FRAC_W-1:0] acc_q, acc_d, p_acc, acc_in;
  logic              byp_q, byp_d, p_byp;
  logic              out_q, out_d, tick_q, tick_d;
  logic signed [FRAC_W:0] ofs, ofs_in;

  assign sel_tick = casc_sel ? casc_tick : src_tick;
  assign cnt_inc  = cnt_q + 1'b1;
  assign bnd      = sel_tick & (byp_q | (cnt_inc == len_q));
  assign fresh    = sync | byp_q;
  assign acc_in   = fresh ? '0 : acc_q;
  assign ofs_in   = fresh ? '0 : ofs;

  fdiv_tri #(.FRAC_W(FRAC_W), .STEP_W(STEP_W), .LEG_W(LEG_W)) u_tri (
    .clk(clk), .rst_n(rst_n),
    .restart(fresh | ~ss_en), .adv(bnd),
    .en(ss_en), .center(ss_center), .step(ss_step), .leg(ss_leg),
    .ofs(ofs)
  );

  fdiv_plan #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_plan (
    .n(int_word), .f(frac_word), .io(int_only), .byp_in(bypass),
    .acc_in(acc_in), .ofs(ofs_in),
    .len(p_len), .acc_out(p_acc), .byp_out(p_byp)
  );

  always_comb begin
    cnt_d  = cnt_q;
    len_d  = len_q;
    acc_d  = acc_q;
    byp_d  = byp_q;
    out_d  = out_q;
    tick_d = 1'b0;
    if (sync) begin
      cnt_d = '0;
      len_d = p_len;
      acc_d = p_acc;
      byp_d = p_byp;
      out_d = 1'b0;
    end else if (bnd) begin
      cnt_d  = '0;
      len_d  = p_len;
      acc_d  = p_acc;
      byp_d  = p_byp;
      tick_d = 1'b1;
      out_d  = byp_q & p_byp;
    end else if (byp_q) begin
      out_d = 1'b0;
    end else if (sel_tick) begin
      cnt_d = cnt_inc;
      if (cnt_inc == {1'b0, len_q[LEN_W-1:1]})
        out_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      len_q  <= LEN_W'(2);
      acc_q  <= '0;
      byp_q  <= 1'b1;
      out_q  <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      len_q  <= len_d;
      acc_q  <= acc_d;
      byp_q  <= byp_d;
      out_q  <= out_d;
      tick_q <= tick_d;
    end
  end

  assign div_out  = out_q;
  assign div_tick = tick_q;
endmodule

// File: rtl/fdiv_spread_chk.sv
module fdiv_spread_chk #(
  parameter int INT_W = 12,
  parameter int LEN_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync,
  input logic             sel_tick,
  input logic             bnd,
  input logic             byp_q,
  input logic             ss_en,
  input logic             ss_center,
  input logic [INT_W-1:0] int_word,
  input logic [LEN_W-1:0] cnt_q,
  input logic [LEN_W-1:0] len_q,
  input logic             div_out,
  input logic             div_tick
);
  p_fall_at_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (div_tick && !byp_q) |-> !div_out);

  p_count_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !byp_q |-> (cnt_q < len_q));

  p_len_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!div_tick && !$past(sync)) |-> $stable(len_q));

  p_sync_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> (!div_out && !div_tick));

  p_pass_through_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (byp_q && $past(byp_q) && !$past(sync)) |-> (div_out == $past(sel_tick)));

  p_down_not_shorter_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd && !byp_q && !sync && ss_en && !ss_center)
      |=> (len_q >= {2'b0, $past(int_word)}));
endmodule

bind fdiv_spread fdiv_spread_chk #(.INT_W(INT_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync(sync), .sel_tick(sel_tick), .bnd(bnd),
  .byp_q(byp_q), .ss_en(ss_en), .ss_center(ss_center), .int_word(int_word),
  .cnt_q(cnt_q), .len_q(len_q), .div_out(div_out), .div_tick(div_tick)
);

// File: tb/test_fdiv_spread.sv
`timescale 1ns/1ps
module test_fdiv_spread;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        src_tick, casc_tick, casc_sel, sync;
  logic [11:0] int_word;
  logic [23:0] frac_word;
  logic        int_only, bypass, ss_en, ss_center;
  logic [15:0] ss_step;
  logic [7:0]  ss_leg;
  logic        div_out, div_tick;

  fdiv_spread i_fdiv_spread (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .casc_tick(casc_tick),
    .casc_sel(casc_sel), .sync(sync), .int_word(int_word), .frac_word(frac_word),
    .int_only(int_only), .bypass(bypass), .ss_en(ss_en), .ss_center(ss_center),
    .ss_step(ss_step), .ss_leg(ss_leg), .div_out(div_out), .div_tick(div_tick)
  );

  always #10 clk = ~clk;

  int     vectors = 0;
  int     miscompares = 0;
  int     cyc_g = 0;
  longint acc_m, tri_m;
  bit     dn_m;
  int     k_m, exp_len, ticks_since;
  bit     prev_out, prev_sel;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Arithmetic model of one planning step (restart when fresh).
  task automatic model_plan(input bit fresh);
    longint ofs = 0;
    longint s;
    if (!fresh && ss_en)
      ofs = ss_center ? tri_m - (longint'(ss_step) * longint'(ss_leg)) / 2 : tri_m;
    s = (fresh ? 0 : acc_m) + (int_only ? 0 : longint'(frac_word) + ofs);
    exp_len = int'(longint'(int_word) + (s >>> 24));
    acc_m   = s & 64'hFF_FFFF;
    if (fresh || !ss_en) begin
      tri_m = 0; dn_m = 0; k_m = 0;
    end else if (ss_leg != 0) begin
      tri_m = dn_m ? tri_m - ss_step : tri_m + ss_step;
      k_m++;
      if (k_m == ss_leg) begin k_m = 0; dn_m = ~dn_m; end
    end
  endtask

  task automatic do_sync(input bit with_tick, input string req);
    @(negedge clk);
    sync = 1'b1; src_tick = with_tick; casc_tick = with_tick;
    @(negedge clk);
    chk(!div_out && !div_tick, req, {div_out, div_tick}, 0);
    sync = 1'b0; src_tick = 1'b0; casc_tick = 1'b0;
    model_plan(1'b1);
    ticks_since = 0;
    prev_out = 1'b0;
  endtask

  task automatic run(input int nper, input int maxt, input int sg, input int cg,
                     input string req);
    int seen = 0;
    int tk = 0;
    while (seen < nper && tk < maxt) begin
      @(negedge clk);
      if (div_tick) begin
        chk(ticks_since == exp_len, req, ticks_since, exp_len);
        chk(!div_out, "R3 fall", div_out, 0);
        model_plan(1'b0);
        ticks_since = 0;
        seen++;
      end else if (div_out && !prev_out) begin
        chk(ticks_since == exp_len / 2, "R3 rise", ticks_since, exp_len / 2);
      end
      prev_out  = div_out;
      cyc_g++;
      src_tick  = (cyc_g % sg) == 0;
      casc_tick = (cyc_g % cg) == 0;
      if (casc_sel ? casc_tick : src_tick) begin
        ticks_since++;
        tk++;
      end
    end
  endtask

  task automatic bypass_window(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(div_out == prev_sel && div_tick == prev_sel, req, {div_out, div_tick}, {prev_sel, prev_sel});
      src_tick = (i % 3) != 2;
      prev_sel = src_tick;
    end
  endtask

  initial begin
    #3_000_000;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_n = 1'b0; src_tick = 0; casc_tick = 0; casc_sel = 0; sync = 0;
    int_word = 12'd1; frac_word = '0; int_only = 1; bypass = 0;
    ss_en = 0; ss_center = 0; ss_step = '0; ss_leg = '0;
    prev_sel = 0; prev_out = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!div_out && !div_tick, "R10 reset", {div_out, div_tick}, 0);
    src_tick = 1'b1;
    @(negedge clk);
    chk(div_out && div_tick, "R10 pass", {div_out, div_tick}, 3);
    src_tick = 1'b0;

    // R1: integer-only sweep, fraction present but ignored
    frac_word = 24'h9A_BCDE; int_only = 1;
    for (int n = 2; n <= 9; n++) begin
      int_word = 12'(n);
      do_sync(0, "R7");
      run(4, 1000, 1, 1, "R1");
    end
    int_word = 12'd5;
    do_sync(0, "R7");
    run(4, 1000, 2, 1, "R1 gap");

    // R2: fractional sweep
    int_only = 0;
    for (int n = 2; n <= 5; n++) begin
      for (int j = 0; j < 5; j++) begin
        int_word = 12'(n);
        case (j)
          0: frac_word = 24'h00_0000;
          1: frac_word = 24'h80_0000;
          2: frac_word = 24'h40_0000;
          3: frac_word = 24'h55_5555;
          default: frac_word = 24'hFF_FFFF;
        endcase
        do_sync(0, "R7");
        run(9, 1000, 1, 1, "R2");
      end
    end

    // R4: ratio change mid-period applies at next boundary
    int_only = 1; int_word = 12'd6;
    do_sync(0, "R7");
    run(100, 2, 1, 1, "R4");
    int_word = 12'd3;
    run(4, 1000, 1, 1, "R4");

    // R7: sync mid-period with a coincident event
    int_word = 12'd8;
    do_sync(0, "R7");
    run(100, 3, 1, 1, "R7");
    do_sync(1, "R7 low");
    run(3, 1000, 1, 1, "R7");

    // R6: cascade input selected
    casc_sel = 1; int_word = 12'd4;
    do_sync(0, "R7");
    run(4, 1000, 1, 3, "R6");
    casc_sel = 0;
    do_sync(0, "R7");
    run(3, 1000, 3, 1, "R6");

    // R5: explicit bypass, then leaving it
    bypass = 1; prev_sel = 0;
    do_sync(0, "R7");
    bypass_window(24, "R5 bypass");
    @(negedge clk);
    chk(div_out == prev_sel && div_tick == prev_sel, "R5 bypass", {div_out, div_tick}, {prev_sel, prev_sel});
    bypass = 0; int_word = 12'd4; src_tick = 1'b1;
    @(negedge clk);
    chk(div_tick && !div_out, "R5 leave", {div_out, div_tick}, 1);
    src_tick = 1'b0;
    model_plan(1'b1); ticks_since = 0; prev_out = 0;
    run(5, 1000, 1, 1, "R5 leave");

    // R5: integer word below 2 acts as bypass
    int_word = 12'd1; prev_sel = 0;
    do_sync(0, "R7");
    bypass_window(12, "R5 n<2");

    // R8: down spread
    int_only = 0; int_word = 12'd4; frac_word = 24'h30_0000;
    ss_en = 1; ss_center = 0; ss_step = 16'h8000; ss_leg = 8'd40;
    do_sync(0, "R7");
    run(200, 100000, 1, 1, "R8");

    // R9: centre spread, shortened periods included
    int_word = 12'd5; frac_word = 24'h08_0000;
    ss_center = 1; ss_step = 16'hC000; ss_leg = 8'd30;
    do_sync(0, "R7");
    run(150, 100000, 1, 1, "R9");

    // R11: spread enabled with zero leg, then disabled
    ss_leg = 8'd0;
    do_sync(0, "R7");
    run(20, 100000, 1, 1, "R11 leg0");
    ss_en = 0; ss_leg = 8'd30;
    do_sync(0, "R7");
    run(20, 100000, 1, 1, "R11 off");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule